// File: doc/BRIEF.md
# Preloaded Edge-Aligned PWM Channel

This block is an up-counting timer with a single compare channel. It produces an edge-aligned pulse-width-modulated waveform. The period comes from a programmable period value and the duty cycle from a programmable compare value. Both values can be buffered in staging registers. A buffered value moves into the working copy that the counter and comparator use only at an update event. An update event is either the natural wrap of the counter or a software-issued update strobe. Software can therefore change the period and duty mid-run without glitching a cycle, and it can load a clean starting state before counting begins.

The block drives two outputs. The first is an internal reference waveform, selectable between two opposite PWM modes. The second is an output pin derived from the reference, with a programmable polarity and an enable that forces the pin low when clear. Software reaches every setting through a simple write port. That port has no back-pressure: a write presented with `wr_en` high is always accepted in that clock. Addresses outside the map are dropped. The counter value and an update indication are brought out as plain status pins.

Top module: `pwm_chan_top`

## Requirements
- R1: After reset the counter, period, compare and control settings are all zero, and both the waveform and the pin are low.
- R2: The counter advances by one each clock. When it is equal to or greater than the working period, it returns to 0 on the next clock, so one period lasts period+1 clocks.
- R3: An update event occurs in any cycle where the counter is at or above the working period, or where address 3 is written (the data is ignored). `upd_o` is high in that cycle. At the next edge the counter becomes 0 and both staged values are copied to the working copies.
- R4: When control bit 4 (compare buffering) is set, a write to address 1 changes only the staged compare value. The working compare value stays unchanged until an update event.
- R5: When control bit 5 (period buffering) is set, a write to address 0 changes only the staged period. The working period stays unchanged until an update event.
- R6: When the matching buffering bit is clear, a write to address 0 or 1 sets the working value at the next clock edge, taking priority over a simultaneous update event.
- R7: The mode field, control bits [3:0], selects the waveform. 4'b0110 drives the waveform high while counter < working compare and low otherwise. 4'b0111 gives the inverse. Every other code holds the waveform low.
- R8: In mode 4'b0110, a working compare greater than the working period keeps the waveform high for the whole period, and a working compare of 0 keeps it low for the whole period.
- R9: Control bit 7 enables the pin and control bit 6 selects polarity. When disabled, the pin is 0. When enabled, the pin equals the waveform XOR the polarity bit.
- R10: Address 0 holds the period, 1 the compare value, 2 the control byte in `wr_data[7:0]`, and 3 the update strobe. Writes to addresses 4 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, always accepted |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W (16) | Write data |
| cnt_o | output | CNT_W (16) | Current counter value |
| upd_o | output | 1 | Update event in this cycle |
| wave_o | output | 1 | Reference waveform |
| pin_o | output | 1 | Polarity-adjusted, gated output pin |

## Verification
The counter feeds both the comparator and the wrap detection. A wrong counter value therefore shows on `cnt_o` at the very next edge, and it moves the waveform edge and the `upd_o` pulse in the same cycle. A staged value copied at the wrong moment shows as a waveform edge that comes one period early or late, or as a period of the wrong length. Either becomes visible within one period of the write. Every clock, the bench compares all four outputs against a behavioural model, so any such error is caught in the first cycle where it becomes observable.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PERIOD  = 3'd0,
    A_COMPARE = 3'd1,
    A_CONTROL = 3'd2,
    A_UPDATE  = 3'd3
  } addr_e;

  localparam logic [3:0] MODE_LOW_AFTER  = 4'b0110;
  localparam logic [3:0] MODE_HIGH_AFTER = 4'b0111;

  typedef struct packed {
    logic       out_en;
    logic       invert;
    logic       per_buf;
    logic       cmp_buf;
    logic [3:0] mode;
  } ctrl_t;
endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         buf_en,
  input  logic         upd,
  output logic [W-1:0] active
);
  logic [W-1:0] staged_q, active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= '0;
      active_q <= '0;
    end else begin
      if (wr) staged_q <= wdata;
      if (wr && !buf_en) active_q <= wdata;
      else if (upd)      active_q <= staged_q;
    end
  end

  assign active = active_q;

  // R4 / R5: with buffering on, the working copy moves only at an update event
  assert_shadow_hold_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && !upd) |=> $stable(active_q));
  // R6: unbuffered write lands next clock
  assert_direct_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !buf_en) |=> (active_q == $past(wdata)));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_upd,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         upd
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  logic [W-1:0] cnt_q;

  assign upd = sw_upd || (cnt_q >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= '0;
    else          cnt_q <= cnt_q + ONE;
  end

  assign cnt = cnt_q;

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> (cnt_q == $past(cnt_q) + ONE));
  assert_upd_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  ctrl_t        ctrl,
  output logic         wave,
  output logic         pin
);
  logic below;
  assign below = cnt < cmp;

  always_comb begin
    unique case (ctrl.mode)
      MODE_LOW_AFTER:  wave = below;
      MODE_HIGH_AFTER: wave = !below;
      default:         wave = 1'b0;
    endcase
  end

  assign pin = ctrl.out_en & (wave ^ ctrl.invert);
endmodule

// File: rtl/pwm_chan_top.sv
module pwm_chan_top
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 upd_o,
  output logic                 wave_o,
  output logic                 pin_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic             wr_per, wr_cmp, wr_ctl, wr_upd;
  logic [CNT_W-1:0] per_act, cmp_act, cnt;
  logic             upd;

  assign wr_per = wr_en && (wr_addr == A_PERIOD);
  assign wr_cmp = wr_en && (wr_addr == A_COMPARE);
  assign wr_ctl = wr_en && (wr_addr == A_CONTROL);
  assign wr_upd = wr_en && (wr_addr == A_UPDATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (wr_ctl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  pwm_shadow_reg #(.W(CNT_W)) u_per (
    .clk(clk), .rst_n(rst_n), .wr(wr_per), .wdata(wr_data),
    .buf_en(ctrl_q.per_buf), .upd(upd), .active(per_act));

  pwm_shadow_reg #(.W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr(wr_cmp), .wdata(wr_data),
    .buf_en(ctrl_q.cmp_buf), .upd(upd), .active(cmp_act));

  pwm_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sw_upd(wr_upd), .period(per_act),
    .cnt(cnt), .upd(upd));

  pwm_wave #(.W(CNT_W)) u_wave (
    .cnt(cnt), .cmp(cmp_act), .ctrl(ctrl_q), .wave(wave_o), .pin(pin_o));

  assign cnt_o = cnt;
  assign upd_o = upd;

  assert_sat_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.mode == MODE_LOW_AFTER && cmp_act > per_act && cnt <= per_act) |-> wave_o);
  assert_zero_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.mode == MODE_LOW_AFTER && cmp_act == '0) |-> !wave_o);
  assert_pin_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.out_en |-> !pin_o);
  assert_strobe_upd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_upd |-> upd_o);
endmodule

// File: tb/pwm_chan_top_tb_top.sv
`timescale 1ns/1ps
module pwm_chan_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_o;
  logic        upd_o, wave_o, pin_o;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit finished = 0;

  // behavioural model state
  int m_cnt = 0, m_per_s = 0, m_per_a = 0, m_cmp_s = 0, m_cmp_a = 0;
  int m_ctl = 0;

  always #4 clk = ~clk;

  pwm_chan_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_o(cnt_o), .upd_o(upd_o),
    .wave_o(wave_o), .pin_o(pin_o));

  task automatic cmp1(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit we, int addr, int data);
    int mode, e_wave, e_pin, e_upd, below;
    @(negedge clk);
    wr_en = we; wr_addr = 3'(addr); wr_data = 16'(data);
    #1;
    mode   = m_ctl & 15;
    below  = (m_cnt < m_cmp_a) ? 1 : 0;
    e_wave = (mode == 6) ? below : (mode == 7) ? 1 - below : 0;
    e_pin  = ((m_ctl >> 7) & 1) ? (e_wave ^ ((m_ctl >> 6) & 1)) : 0;
    e_upd  = ((we && addr == 3) || m_cnt >= m_per_a) ? 1 : 0;
    cmp1("cnt_o", int'(cnt_o), m_cnt);
    cmp1("upd_o", int'(upd_o), e_upd);
    cmp1("wave_o", int'(wave_o), e_wave);
    cmp1("pin_o", int'(pin_o), e_pin);
    @(posedge clk);
    begin
      int n_per_a, n_cmp_a;
      n_per_a = m_per_a; n_cmp_a = m_cmp_a;
      if (we && addr == 0 && !((m_ctl >> 5) & 1)) n_per_a = data;
      else if (e_upd) n_per_a = m_per_s;
      if (we && addr == 1 && !((m_ctl >> 4) & 1)) n_cmp_a = data;
      else if (e_upd) n_cmp_a = m_cmp_s;
      if (we && addr == 0) m_per_s = data;
      if (we && addr == 1) m_cmp_s = data;
      if (we && addr == 2) m_ctl = data & 255;
      m_cnt = e_upd ? 0 : m_cnt + 1;
      m_per_a = n_per_a; m_cmp_a = n_cmp_a;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #20 rst_n = 1'b1;
    cur_req = "R1"; idle(3);
    cur_req = "R10"; step(1, 2, 'h86); step(1, 0, 9); step(1, 1, 4);
    cur_req = "R7"; idle(25);
    cur_req = "R9"; step(1, 2, 'hC6); idle(12); step(1, 2, 'h46); idle(6);
    cur_req = "R7"; step(1, 2, 'h87); idle(12); step(1, 2, 'h85); idle(8);
    cur_req = "R4"; step(1, 2, 'h96); idle(2); step(1, 1, 7); idle(22);
    cur_req = "R5"; step(1, 2, 'hB6); idle(1); step(1, 0, 5); idle(20);
    cur_req = "R3"; step(1, 0, 12); idle(2); step(1, 3, 'hFFFF); idle(16);
    cur_req = "R8"; step(1, 1, 20); step(1, 3, 0); idle(30);
    step(1, 1, 0); step(1, 3, 0); idle(15);
    cur_req = "R6"; step(1, 2, 'h86); step(1, 1, 6); idle(10); step(1, 0, 3); idle(12);
    cur_req = "R2"; step(1, 0, 14); idle(11); step(1, 0, 2); idle(10);
    cur_req = "R10"; step(1, 5, 'h11); step(1, 7, 'h00); step(1, 4, 1); idle(10);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule